// File: doc/BRIEF.md
# Companion-Chip System Control Register Bank

This block is the system control register bank of a companion I/O chip. A host reaches it over a simple byte-wide bus: an 8-bit offset, an 8-bit write data bus with a write strobe, and an 8-bit read data bus that always shows the byte at the current offset. The bank holds a fixed two-byte revision code, an interrupt status byte, an interrupt mask byte and an interrupt routing byte. It also holds a set of storage registers for clock, two PLLs, function enable, mode, configuration and debug. The storage registers keep what the host writes and drive nothing else.

Eight level-sensitive interrupt lines come in from sub-units. When a line changes level, its status bit takes the new level. Software may also write the status byte directly, and that value holds until the next change on a line. A single interrupt output is high while any status bit whose mask bit is set is also set. Registers wider than a byte are reached one byte lane at a time, low byte at the lowest offset.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset every readable register except the revision code reads 0x00, and irq_out is low.
- R2: Offset 0x08 reads 0x03 and offset 0x09 reads 0x00. Writes to either offset change neither value.
- R3: When unit_irq bit i changes level at a clock edge, status bit i (offset 0x50) reads that new level after the edge. Status bits whose line did not change keep their value.
- R4: A write to offset 0x50 loads the written byte into the status register when no interrupt line changes in that cycle.
- R5: irq_out is high exactly when (status AND mask) is nonzero, where the mask is the byte at offset 0x52. It follows mask writes as well as status updates.
- R6: The 16-bit registers (clock control at 0x98/0x99, PLL2 control at 0x9A/0x9B, mode control at 0xE4/0xE5) hold the low byte at the lower offset and the high byte at the next offset. A write to one lane leaves the other lane unchanged.
- R7: The 32-bit PLL1 control register holds byte k at offset 0x9C+k for k = 0..3, and each lane is written on its own.
- R8: The byte registers for routing (0x54), function enable (0xE0), configuration (0xFC) and debug (0xFF) read back the last byte written to them.
- R9: Reads of any offset not named in R2 to R8 return 0x00. Writes to such offsets change no register.
- R10: When a status write and a change on an interrupt line fall in the same cycle, each bit whose line changed takes the line level. All other bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Write strobe; writes host_wdata at host_addr on the clock edge |
| host_addr | input | 8 | Byte offset for reads and writes |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Byte at host_addr (combinational) |
| unit_irq | input | 8 | Level-sensitive sub-unit interrupt lines |
| irq_out | output | 1 | Combined interrupt, high when an unmasked status bit is set |

## Verification
The hardest case to reach from the ports is a software write to the status byte that lands in the same cycle as a level change on some interrupt lines. Each bit must then come from a different source. Ordinary stimulus rarely lines the two up, so a directed case writes a status pattern while one line rises. The random phase also toggles lines on about a quarter of the cycles and aims about half of its writes at mapped offsets, so the two events often coincide. A bench model predicts every readback and the interrupt output throughout.

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter logic [7:0] REV_LO = 8'h03,
  parameter logic [7:0] REV_HI = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic [7:0] unit_irq,
  output logic       irq_out
);

  localparam logic [7:0] OFF_REV   = 8'h08;
  localparam logic [7:0] OFF_STAT  = 8'h50;
  localparam logic [7:0] OFF_MASK  = 8'h52;
  localparam logic [7:0] OFF_ROUTE = 8'h54;
  localparam logic [7:0] OFF_CLKC  = 8'h98;
  localparam logic [7:0] OFF_PLL2  = 8'h9A;
  localparam logic [7:0] OFF_PLL1  = 8'h9C;
  localparam logic [7:0] OFF_FEN   = 8'hE0;
  localparam logic [7:0] OFF_MODE  = 8'hE4;
  localparam logic [7:0] OFF_CFG   = 8'hFC;
  localparam logic [7:0] OFF_DBG   = 8'hFF;

  logic [7:0]  stat_q, mask_q, route_q, fen_q, cfg_q, dbg_q, src_q;
  logic [15:0] clkc_q, pll2_q, mode_q;
  logic [31:0] pll1_q;
  logic [7:0]  stat_wr, src_chg, stat_nxt;

  assign stat_wr  = (host_we && host_addr == OFF_STAT) ? host_wdata : stat_q;
  assign src_chg  = unit_irq ^ src_q;
  assign stat_nxt = (stat_wr & ~src_chg) | (unit_irq & src_chg);
  assign irq_out  = |(stat_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      src_q   <= '0;
      mask_q  <= '0;
      route_q <= '0;
      fen_q   <= '0;
      cfg_q   <= '0;
      dbg_q   <= '0;
      clkc_q  <= '0;
      pll2_q  <= '0;
      mode_q  <= '0;
      pll1_q  <= '0;
    end else begin
      src_q  <= unit_irq;
      stat_q <= stat_nxt;
      if (host_we) begin
        case (host_addr)
          OFF_MASK:         mask_q        <= host_wdata;
          OFF_ROUTE:        route_q       <= host_wdata;
          OFF_CLKC:         clkc_q[7:0]   <= host_wdata;
          OFF_CLKC + 8'd1:  clkc_q[15:8]  <= host_wdata;
          OFF_PLL2:         pll2_q[7:0]   <= host_wdata;
          OFF_PLL2 + 8'd1:  pll2_q[15:8]  <= host_wdata;
          OFF_PLL1:         pll1_q[7:0]   <= host_wdata;
          OFF_PLL1 + 8'd1:  pll1_q[15:8]  <= host_wdata;
          OFF_PLL1 + 8'd2:  pll1_q[23:16] <= host_wdata;
          OFF_PLL1 + 8'd3:  pll1_q[31:24] <= host_wdata;
          OFF_FEN:          fen_q         <= host_wdata;
          OFF_MODE:         mode_q[7:0]   <= host_wdata;
          OFF_MODE + 8'd1:  mode_q[15:8]  <= host_wdata;
          OFF_CFG:          cfg_q         <= host_wdata;
          OFF_DBG:          dbg_q         <= host_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (host_addr)
      OFF_REV:          host_rdata = REV_LO;
      OFF_REV + 8'd1:   host_rdata = REV_HI;
      OFF_STAT:         host_rdata = stat_q;
      OFF_MASK:         host_rdata = mask_q;
      OFF_ROUTE:        host_rdata = route_q;
      OFF_CLKC:         host_rdata = clkc_q[7:0];
      OFF_CLKC + 8'd1:  host_rdata = clkc_q[15:8];
      OFF_PLL2:         host_rdata = pll2_q[7:0];
      OFF_PLL2 + 8'd1:  host_rdata = pll2_q[15:8];
      OFF_PLL1:         host_rdata = pll1_q[7:0];
      OFF_PLL1 + 8'd1:  host_rdata = pll1_q[15:8];
      OFF_PLL1 + 8'd2:  host_rdata = pll1_q[23:16];
      OFF_PLL1 + 8'd3:  host_rdata = pll1_q[31:24];
      OFF_FEN:          host_rdata = fen_q;
      OFF_MODE:         host_rdata = mode_q[7:0];
      OFF_MODE + 8'd1:  host_rdata = mode_q[15:8];
      OFF_CFG:          host_rdata = cfg_q;
      OFF_DBG:          host_rdata = dbg_q;
      default:          host_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_we,
  input logic [7:0] host_addr,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic [7:0] unit_irq,
  input logic       irq_out,
  input logic [7:0] stat_q
);

  a_r2_rev_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 8'h08) |-> (host_rdata == 8'h03));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 8'h00 || host_addr == 8'h51) |-> (host_rdata == 8'h00));

  a_r3_follow_level: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_irq != $past(unit_irq)) |=>
      (((stat_q ^ $past(unit_irq)) & ($past(unit_irq) ^ $past(unit_irq, 2))) == 8'h00));

  a_r4_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == 8'h50 && unit_irq == $past(unit_irq) && $past(rst_n)) |=>
      (stat_q == $past(host_wdata)));

  a_r5_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == 8'h52 && host_wdata == 8'h00) |=> !irq_out);

endmodule

bind sysctl_regfile sysctl_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .unit_irq(unit_irq),
  .irq_out(irq_out), .stat_q(stat_q)
);

// File: tb/sysctl_regfile_tb.sv
module sysctl_regfile_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, host_we = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0, unit_irq = '0;
  logic [7:0] host_rdata;
  logic irq_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0] m_store [0:255];
  logic [7:0] m_stat = '0, m_prev = '0;

  always #2 clk = ~clk;

  sysctl_regfile dut_i (.clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .unit_irq(unit_irq), .irq_out(irq_out));

  function automatic bit is_store(logic [7:0] a);
    return a == 8'h52 || a == 8'h54 || (a >= 8'h98 && a <= 8'h9F) ||
           a == 8'hE0 || a == 8'hE4 || a == 8'hE5 || a == 8'hFC || a == 8'hFF;
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a);
    if (a == 8'h08) return 8'h03;
    if (a == 8'h09) return 8'h00;
    if (a == 8'h50) return m_stat;
    if (is_store(a)) return m_store[a];
    return 8'h00;
  endfunction

  function automatic logic exp_irq();
    return |(m_stat & m_store[8'h52]);
  endfunction

  function automatic logic [7:0] mapped(int i);
    case (i % 20)
      0: return 8'h08;  1: return 8'h09;  2: return 8'h50;  3: return 8'h52;
      4: return 8'h54;  5: return 8'h98;  6: return 8'h99;  7: return 8'h9A;
      8: return 8'h9B;  9: return 8'h9C;  10: return 8'h9D; 11: return 8'h9E;
      12: return 8'h9F; 13: return 8'hE0; 14: return 8'hE4; 15: return 8'hE5;
      16: return 8'hFC; 17: return 8'hFF; 18: return 8'h51; default: return 8'h53;
    endcase
  endfunction

  task automatic cycle(input logic we, input logic [7:0] a, input logic [7:0] d, input logic [7:0] src);
    logic [7:0] nst, chg;
    @(negedge clk);
    host_we = we; host_addr = a; host_wdata = d; unit_irq = src;
    @(posedge clk);
    nst = m_stat;
    if (we && a == 8'h50) nst = d;
    else if (we && is_store(a)) m_store[a] = d;
    chg = src ^ m_prev;
    m_stat = (nst & ~chg) | (src & chg);
    m_prev = src;
  endtask

  task automatic chk(input logic [7:0] a, input string req);
    @(negedge clk);
    host_we = 1'b0; host_addr = a;
    #1;
    checks++;
    if (host_rdata !== exp_read(a)) begin
      errors++;
      $display("FAIL %s read 0x%02h: got 0x%02h exp 0x%02h", req, a, host_rdata, exp_read(a));
    end
    checks++;
    if (irq_out !== exp_irq()) begin
      errors++;
      $display("FAIL %s irq_out: got %0b exp %0b", req, irq_out, exp_irq());
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_store[i] = 8'h00;
    void'($urandom(32'd4321));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk(8'h50, "R1"); chk(8'h52, "R1"); chk(8'h54, "R1"); chk(8'h98, "R1");
    chk(8'h9C, "R1"); chk(8'hE4, "R1"); chk(8'hFC, "R1"); chk(8'hFF, "R1");
    // R2 revision code, writes ignored
    cycle(1, 8'h08, 8'hAA, 8'h00); cycle(1, 8'h09, 8'h55, 8'h00);
    chk(8'h08, "R2"); chk(8'h09, "R2");
    // R3 status follows line levels
    cycle(0, 8'h00, 8'h00, 8'h05); chk(8'h50, "R3");
    cycle(0, 8'h00, 8'h00, 8'h04); chk(8'h50, "R3");
    // R5 mask write updates irq_out
    cycle(1, 8'h52, 8'h04, 8'h04); chk(8'h52, "R5");
    cycle(1, 8'h52, 8'h00, 8'h04); chk(8'h50, "R5");
    // R4 software write to status
    cycle(1, 8'h50, 8'hF0, 8'h04); chk(8'h50, "R4");
    // R10 status write coinciding with a line rising
    cycle(1, 8'h50, 8'h00, 8'h0C); chk(8'h50, "R10");
    cycle(1, 8'h52, 8'h08, 8'h0C); chk(8'h50, "R10");
    // R6 independent 16-bit lanes
    cycle(1, 8'h98, 8'h12, 8'h0C); cycle(1, 8'h99, 8'h34, 8'h0C);
    cycle(1, 8'hE5, 8'hAB, 8'h0C); cycle(1, 8'hE4, 8'hCD, 8'h0C);
    cycle(1, 8'h9B, 8'h77, 8'h0C);
    chk(8'h98, "R6"); chk(8'h99, "R6"); chk(8'hE4, "R6"); chk(8'hE5, "R6");
    chk(8'h9A, "R6"); chk(8'h9B, "R6");
    // R7 PLL1 lanes
    cycle(1, 8'h9E, 8'hC3, 8'h0C); cycle(1, 8'h9C, 8'h11, 8'h0C);
    chk(8'h9C, "R7"); chk(8'h9D, "R7"); chk(8'h9E, "R7"); chk(8'h9F, "R7");
    // R8 byte registers
    cycle(1, 8'h54, 8'h3C, 8'h0C); cycle(1, 8'hE0, 8'h81, 8'h0C);
    cycle(1, 8'hFC, 8'h5A, 8'h0C); cycle(1, 8'hFF, 8'hE7, 8'h0C);
    chk(8'h54, "R8"); chk(8'hE0, "R8"); chk(8'hFC, "R8"); chk(8'hFF, "R8");
    // R9 unmapped offsets
    cycle(1, 8'h51, 8'h77, 8'h0C); cycle(1, 8'h53, 8'hFF, 8'h0C); cycle(1, 8'hA0, 8'h99, 8'h0C);
    chk(8'h51, "R9"); chk(8'h53, "R9"); chk(8'hA0, "R9"); chk(8'h52, "R9"); chk(8'h00, "R9");
    // Random phase covering R3 R4 R5 R10 R6 R7 R8 R9
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a, src;
      a = ($urandom % 2 == 0) ? mapped($urandom % 20) : 8'($urandom);
      src = ($urandom % 4 == 0) ? (unit_irq ^ 8'($urandom)) : unit_irq;
      cycle($urandom % 3 != 0, a, 8'($urandom), src);
      chk(($urandom % 2 == 0) ? mapped($urandom % 20) : 8'($urandom), "R3/R5 random");
      chk(8'h50, "R10 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired before all requirement checks completed");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule